// File: doc/BRIEF.md
# Hash-Chained Snapshot Sequencer

This block paces the creation of a memory snapshot one entry at a time. A trigger pulse puts it into snapshot mode: it clears its running digest and its frame index and latches the processor register state presented at that moment. Untrusted software then writes a nonce. From that point the block walks the page frames in ascending order. For each frame it asks an external data mover to copy the page into a buffer that software can read. It then presents the frame index, the nonce and the running digest to an external hash core, which reads the page contents itself. The digest that comes back becomes the new running value.

After each entry the block clears the semaphore to zero and waits. Software copies the buffer out and writes a non-zero semaphore value to request the next entry. After the last frame, one more hash step chains the captured register state under index N. The block then asks the mover to place that closing entry in the buffer, raises a done flag, leaves snapshot mode and holds the final digest for a signing unit. Both handshakes use a level request that stays high until a one-cycle acknowledge pulse arrives.

Top module: `snap_chain_seq`

## Requirements
- R1: After reset the block is out of snapshot mode. Done is low, both requests are low and the semaphore reads 0.
- R2: A trigger pulse received out of snapshot mode enters snapshot mode. It sets the running digest and the index to 0, sets the semaphore to all ones and latches the register-state input.
- R3: In snapshot mode, before the sweep starts, a non-zero nonce write (select 0) starts a transfer of frame 0. A zero nonce write starts nothing.
- R4: Nonce writes are ignored out of snapshot mode and once the sweep has started. The nonce on the hash port stays the one that started the sweep.
- R5: Frames are transferred in ascending order, 0 to N-1. Each hash step for a frame presents that frame's index and the sweep nonce, with the final-step flag low.
- R6: On hash acknowledge the returned digest is latched. The next hash step presents it as the running digest.
- R7: Once an entry is complete, the semaphore reads 0. While it reads 0 the block issues no transfer and no hash request.
- R8: A non-zero semaphore write (select 1) while waiting stores the value and advances to the next entry. A zero semaphore write is ignored.
- R9: After frame N-1 is released, one final hash step runs with the final-step flag high, index N, the latched register state and the running digest.
- R10: The closing entry is transferred as frame N. Then done rises, snapshot mode ends, the semaphore reads 0, and the final digest and done stay stable until the next trigger.
- R11: A new trigger clears done and starts a fresh chain from a zero digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_enter | input | 1 | Trigger pulse to enter snapshot mode |
| cpu_regs | input | REG_W | Register state, latched on entry |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 1 | 0 selects the nonce, 1 selects the semaphore |
| sw_wdata | input | DATA_W | Software write data |
| sema_q | output | DATA_W | Semaphore value as read by software |
| snap_active | output | 1 | Snapshot mode |
| snap_done | output | 1 | Final entry emitted, digest ready |
| xfer_req | output | 1 | Entry transfer request |
| xfer_done | input | 1 | Transfer finished pulse |
| entry_idx | output | IDX_W | Index of the entry being transferred or hashed |
| hash_req | output | 1 | Hash step request |
| hash_final | output | 1 | Step chains the register state instead of a page |
| hash_nonce | output | DATA_W | Sweep nonce |
| hash_acc | output | DIG_W | Running digest |
| hash_regs | output | REG_W | Latched register state |
| hash_ack | input | 1 | Hash step finished pulse |
| hash_dig | input | DIG_W | Digest returned by the hash core |
| final_dig | output | DIG_W | Chained digest for signing |

## Verification
The states that are hardest to reach are the ones where software misbehaves inside the sweep. These include a second nonce write after frame 0 is under way, a zero written to the semaphore while the block waits, and register traffic after done. The bench plays the data mover, the hash core and the driver in a single sequence. It injects these writes at fixed points of a full sweep and then checks the next hash request or the held outputs. Each hash response comes from an arithmetic model of the expected chain, so any error in the digest ordering shows up in the final digest.

// File: rtl/snap_chain_pkg.sv
package snap_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_XFER  = 3'd2,
    ST_HASH  = 3'd3,
    ST_WAIT  = 3'd4,
    ST_FHASH = 3'd5,
    ST_FXFER = 3'd6
  } seq_st_e;

  localparam logic SEL_NONCE = 1'b0;
  localparam logic SEL_SEMA  = 1'b1;
endpackage

// File: rtl/snap_seq_ctrl.sv
module snap_seq_ctrl
  import snap_chain_pkg::*;
#(
  parameter int N_FRAMES = 1024,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = $clog2(N_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_enter,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              xfer_done,
  input  logic              hash_ack,
  output logic [DATA_W-1:0] sema_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              done_q,
  output logic              active,
  output logic              xfer_req,
  output logic              hash_req,
  output logic              hash_final,
  output logic              clr_chain,
  output logic              nonce_ld,
  output logic              acc_ld
);
  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(N_FRAMES - 1);
  localparam logic [IDX_W-1:0] CLOSE_IDX  = IDX_W'(N_FRAMES);

  seq_st_e           st_q, st_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] sema_d;
  logic              done_d;
  logic              wr_nz, advance;

  assign wr_nz   = sw_we && (sw_wdata != '0);
  assign advance = (st_q == ST_WAIT) && wr_nz && (sw_sel == SEL_SEMA);

  assign active     = (st_q != ST_IDLE);
  assign xfer_req   = (st_q == ST_XFER) || (st_q == ST_FXFER);
  assign hash_req   = (st_q == ST_HASH) || (st_q == ST_FHASH);
  assign hash_final = (st_q == ST_FHASH);
  assign clr_chain  = (st_q == ST_IDLE) && snap_enter;
  assign nonce_ld   = (st_q == ST_ARMED) && wr_nz && (sw_sel == SEL_NONCE);
  assign acc_ld     = hash_req && hash_ack;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sema_d = sema_q;
    done_d = done_q;
    unique case (st_q)
      ST_IDLE: if (snap_enter) begin
        st_d   = ST_ARMED;
        idx_d  = '0;
        sema_d = '1;
        done_d = 1'b0;
      end
      ST_ARMED: if (nonce_ld) st_d = ST_XFER;
      ST_XFER:  if (xfer_done) st_d = ST_HASH;
      ST_HASH:  if (hash_ack) begin
        st_d   = ST_WAIT;
        sema_d = '0;
      end
      ST_WAIT: if (advance) begin
        sema_d = sw_wdata;
        if (idx_q == LAST_FRAME) begin
          idx_d = CLOSE_IDX;
          st_d  = ST_FHASH;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_XFER;
        end
      end
      ST_FHASH: if (hash_ack) st_d = ST_FXFER;
      ST_FXFER: if (xfer_done) begin
        st_d   = ST_IDLE;
        sema_d = '0;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sema_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sema_q <= sema_d;
      done_q <= done_d;
    end
  end

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> idx_q <= CLOSE_IDX);
  p_final_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hash_final |-> idx_q == CLOSE_IDX);
  p_zero_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && sw_we && sw_sel == SEL_SEMA && sw_wdata == '0)
      |=> sema_q == '0);
endmodule

// File: rtl/snap_chain_accum.sv
module snap_chain_accum #(
  parameter int DATA_W = 64,
  parameter int REG_W  = 64,
  parameter int DIG_W  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_chain,
  input  logic              nonce_ld,
  input  logic              acc_ld,
  input  logic [DATA_W-1:0] nonce_in,
  input  logic [REG_W-1:0]  regs_in,
  input  logic [DIG_W-1:0]  dig_in,
  output logic [DATA_W-1:0] nonce_q,
  output logic [REG_W-1:0]  regs_q,
  output logic [DIG_W-1:0]  acc_q
);
  logic [DATA_W-1:0] nonce_d;
  logic [REG_W-1:0]  regs_d;
  logic [DIG_W-1:0]  acc_d;

  always_comb begin
    nonce_d = nonce_ld  ? nonce_in : nonce_q;
    regs_d  = clr_chain ? regs_in  : regs_q;
    if (clr_chain)   acc_d = '0;
    else if (acc_ld) acc_d = dig_in;
    else             acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nonce_q <= '0;
      regs_q  <= '0;
      acc_q   <= '0;
    end else begin
      nonce_q <= nonce_d;
      regs_q  <= regs_d;
      acc_q   <= acc_d;
    end
  end

  p_acc_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && !clr_chain) |=> acc_q == $past(dig_in));
endmodule

// File: rtl/snap_chain_seq.sv
module snap_chain_seq #(
  parameter int N_FRAMES = 1024,
  parameter int DATA_W   = 64,
  parameter int REG_W    = 64,
  parameter int DIG_W    = 256,
  parameter int IDX_W    = $clog2(N_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_enter,
  input  logic [REG_W-1:0]  cpu_regs,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sema_q,
  output logic              snap_active,
  output logic              snap_done,
  output logic              xfer_req,
  input  logic              xfer_done,
  output logic [IDX_W-1:0]  entry_idx,
  output logic              hash_req,
  output logic              hash_final,
  output logic [DATA_W-1:0] hash_nonce,
  output logic [DIG_W-1:0]  hash_acc,
  output logic [REG_W-1:0]  hash_regs,
  input  logic              hash_ack,
  input  logic [DIG_W-1:0]  hash_dig,
  output logic [DIG_W-1:0]  final_dig
);
  logic clr_chain, nonce_ld, acc_ld;
  logic sweeping;

  snap_seq_ctrl #(
    .N_FRAMES(N_FRAMES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .snap_enter(snap_enter),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .xfer_done(xfer_done), .hash_ack(hash_ack),
    .sema_q(sema_q), .idx_q(entry_idx), .done_q(snap_done),
    .active(snap_active), .xfer_req(xfer_req), .hash_req(hash_req),
    .hash_final(hash_final), .clr_chain(clr_chain),
    .nonce_ld(nonce_ld), .acc_ld(acc_ld)
  );

  snap_chain_accum #(
    .DATA_W(DATA_W), .REG_W(REG_W), .DIG_W(DIG_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .clr_chain(clr_chain),
    .nonce_ld(nonce_ld), .acc_ld(acc_ld),
    .nonce_in(sw_wdata), .regs_in(cpu_regs), .dig_in(hash_dig),
    .nonce_q(hash_nonce), .regs_q(hash_regs), .acc_q(hash_acc)
  );

  assign final_dig = hash_acc;
  assign sweeping  = xfer_req || hash_req || (snap_active && sema_q == '0);

  p_clear_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snap_active) |-> (hash_acc == '0 && entry_idx == '0));
  p_nonce_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && $past(sweeping)) |-> $stable(hash_nonce));
  p_hold_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_active && sema_q == '0) |-> (!xfer_req && !hash_req));
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_done && !snap_enter) |=> (snap_done && $stable(final_dig) && !snap_active));
endmodule

// File: tb/snap_chain_seq_tb.sv
module snap_chain_seq_tb;
  localparam int N     = 4;
  localparam int DW    = 64;
  localparam int RW    = 64;
  localparam int GW    = 256;
  localparam int IW    = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snap_enter = 1'b0;
  logic [RW-1:0] cpu_regs = '0;
  logic          sw_we = 1'b0;
  logic          sw_sel = 1'b0;
  logic [DW-1:0] sw_wdata = '0;
  logic [DW-1:0] sema_q;
  logic          snap_active, snap_done, xfer_req, hash_req, hash_final;
  logic          xfer_done = 1'b0;
  logic          hash_ack = 1'b0;
  logic [IW-1:0] entry_idx;
  logic [DW-1:0] hash_nonce;
  logic [GW-1:0] hash_acc, final_dig;
  logic [GW-1:0] hash_dig = '0;
  logic [RW-1:0] hash_regs;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  snap_chain_seq #(.N_FRAMES(N), .DATA_W(DW), .REG_W(RW), .DIG_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .snap_enter(snap_enter), .cpu_regs(cpu_regs),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sema_q(sema_q),
    .snap_active(snap_active), .snap_done(snap_done), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .entry_idx(entry_idx), .hash_req(hash_req),
    .hash_final(hash_final), .hash_nonce(hash_nonce), .hash_acc(hash_acc),
    .hash_regs(hash_regs), .hash_ack(hash_ack), .hash_dig(hash_dig),
    .final_dig(final_dig)
  );

  function automatic logic [GW-1:0] hmodel(input int i, input logic [DW-1:0] n,
      input logic [GW-1:0] a, input logic [RW-1:0] r);
    logic [GW-1:0] mix;
    mix = {n, 64'(i) * 64'h9E37_79B9, r, n ^ 64'hA5A5_5A5A_0F0F_F0F0};
    return {a[GW-6:0], a[GW-1:GW-5]} ^ mix ^ GW'(i + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [GW-1:0] act,
      input logic [GW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic sel, input logic [DW-1:0] d);
    sw_sel = sel; sw_wdata = d; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; sw_wdata = '0;
  endtask

  task automatic wait_xfer();
    for (int k = 0; k < 100 && !xfer_req; k++) @(negedge clk);
  endtask

  task automatic wait_hash();
    for (int k = 0; k < 100 && !hash_req; k++) @(negedge clk);
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (xfer_req || hash_req) seen = 1'b1;
    end
    chk(!seen, tag, GW'(seen), '0);
  endtask

  task automatic run_snap(input logic [DW-1:0] nonce, input logic [RW-1:0] regs,
      input bit abuse);
    logic [GW-1:0] acc = '0;
    logic [GW-1:0] held;
    cpu_regs = regs; snap_enter = 1'b1;
    @(negedge clk);
    snap_enter = 1'b0; cpu_regs = '0;
    chk(snap_active && !snap_done, "R2/R11 enter", GW'({snap_active, snap_done}), GW'(2'b10));
    chk(hash_acc == '0 && entry_idx == '0, "R2 cleared", hash_acc, '0);
    chk(sema_q == '1, "R2 sema", GW'(sema_q), GW'({DW{1'b1}}));
    sw_write(1'b0, '0);
    quiet(3, "R3 zero nonce");
    sw_write(1'b0, nonce);
    for (int f = 0; f < N; f++) begin
      wait_xfer();
      chk(xfer_req && entry_idx == IW'(f), "R5 frame order", GW'(entry_idx), GW'(f));
      xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
      wait_hash();
      chk(hash_req && !hash_final && entry_idx == IW'(f), "R5 hash idx", GW'(entry_idx), GW'(f));
      chk(hash_nonce == nonce, "R4/R5 nonce", GW'(hash_nonce), GW'(nonce));
      chk(hash_acc == acc, "R6 chained acc", hash_acc, acc);
      hash_dig = hmodel(f, nonce, acc, '0);
      acc = hash_dig;
      hash_ack = 1'b1; @(negedge clk); hash_ack = 1'b0; hash_dig = '0;
      chk(sema_q == '0, "R7 sema zero", GW'(sema_q), '0);
      quiet(3, "R7 hold");
      if (abuse) begin
        sw_write(1'b0, nonce ^ 64'hFFFF);
        sw_write(1'b1, '0);
        chk(sema_q == '0, "R8 zero sema ignored", GW'(sema_q), '0);
        quiet(2, "R8 no advance");
      end
      sw_write(1'b1, DW'(f + 7));
      chk(sema_q == DW'(f + 7), "R8 sema stored", GW'(sema_q), GW'(f + 7));
    end
    wait_hash();
    chk(hash_req && hash_final && entry_idx == IW'(N), "R9 final step", GW'(entry_idx), GW'(N));
    chk(hash_regs == regs && hash_acc == acc, "R9 regs/acc", GW'(hash_regs), GW'(regs));
    hash_dig = hmodel(N, nonce, acc, regs);
    acc = hash_dig;
    hash_ack = 1'b1; @(negedge clk); hash_ack = 1'b0; hash_dig = '0;
    wait_xfer();
    chk(xfer_req && entry_idx == IW'(N), "R10 close frame", GW'(entry_idx), GW'(N));
    chk(!snap_done, "R10 done late", GW'(snap_done), '0);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk(snap_done && !snap_active && sema_q == '0, "R10 done", GW'({snap_done, snap_active}), GW'(2'b10));
    chk(final_dig == acc, "R10 final digest", final_dig, acc);
    held = final_dig;
    sw_write(1'b0, 64'h1234);
    sw_write(1'b1, 64'h55);
    quiet(4, "R10 idle quiet");
    chk(snap_done && final_dig == held && sema_q == '0, "R10 held", final_dig, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!snap_active && !snap_done && !xfer_req && !hash_req && sema_q == '0,
        "R1 reset", GW'({snap_active, snap_done, xfer_req, hash_req}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    sw_write(1'b0, 64'hDEAD);
    quiet(3, "R4 idle nonce");
    chk(!snap_active, "R4 idle stays", GW'(snap_active), '0);
    run_snap(64'h0123_4567_89AB_CDEF, 64'h0000_7000_1000_0000, 1'b1);
    run_snap(64'h0F1E_2D3C_4B5A_6978, 64'hFEED_0000_0000_BEEF, 1'b0);
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule